// File: doc/BRIEF.md
# Multiplexed Pixel Output Formatter

This block serialises the 16-bit results of up to three colour channels (red, green, blue) onto one 8-bit output bus. It emits one slice per cycle of its clock. That clock runs at the output slot rate, which is twice the conversion-clock rate. A 3-bit channel code sets how many channels a pixel carries and in which order they are sent. A format bit splits each sample either into two bytes or into four nibbles. In nibble form the nibbles ride on the upper four bus lines.

Each accepted sample enters a fixed-length delay pipe, together with the channel code, format and readback flag that were present when it was captured. The first slice of a pixel therefore appears a fixed number of slots after capture: 9 conversion cycles in byte form and 18 in nibble form. A later change of the mode inputs cannot disturb a pixel that is already in flight.

In readback mode the block sends a zero-padded register value in place of the pixel data, once per pixel, for as long as readback stays on. A separate high-impedance request turns off the bus driver enable.

Top module: `pixout_fmt`

## Requirements
- R1: The channel code `chan_code` picks the channel sequence of a pixel, with channel indices 0 = red, 1 = green, 2 = blue. The codes are: 000 sends red, green, blue; 001 sends red only; 010 sends green only; 011 sends blue only; 100 sends red then green; 101 sends green then red; 110 sends green then blue; 111 sends blue then red.
- R2: In byte form (`nibble_mode` = 0), each channel word goes out as bits 15:8 on `pix_bus[7:0]` and then bits 7:0, one per slot.
- R3: In nibble form (`nibble_mode` = 1), each channel word goes out as bits 15:12, 11:8, 7:4 and then 3:0 on `pix_bus[7:4]`, one per slot. `pix_bus[3:0]` is zero during these slots.
- R4: All slices of one channel are sent before any slice of the next channel in the sequence.
- R5: If `smp_vld` is sampled high at clock edge k, the first slice of that pixel is on the bus after edge k + 2·LAT_BYTE in byte form, or after edge k + 2·LAT_NIB in nibble form. With the defaults these are 18 and 36 slots.
- R6: If `rb_en` is high when a sample is captured, every channel slot of that pixel carries the 16-bit word {6'b0, `rb_word`} in the captured format and channel sequence. This repeats on every captured pixel while `rb_en` stays high.
- R7: `bus_oe` is the complement of `out_hiz`, registered at the next clock edge. `out_hiz` has no effect on `pix_bus` or `slot_vld`.
- R8: The channel code, format and readback flag are taken with the sample at capture. Changing them afterwards does not alter a pixel already accepted.
- R9: `slot_vld` is high exactly in the slots that carry a slice. Samples spaced by one pixel period produce a gap-free slice stream.
- R10: After reset, `slot_vld` is 0, `pix_bus` is 0 and `bus_oe` is 0. `pix_bus` is 0 in every slot without a slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, two slots per conversion-clock period |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe; captures the three channel words |
| smp_r | input | 16 | Red conversion result |
| smp_g | input | 16 | Green conversion result |
| smp_b | input | 16 | Blue conversion result |
| chan_code | input | 3 | Channel count and order code |
| nibble_mode | input | 1 | 0 selects byte slices, 1 selects nibble slices |
| rb_en | input | 1 | Replace pixel data with the readback word |
| rb_word | input | 10 | Register value sent in readback mode |
| out_hiz | input | 1 | Request to release the data bus |
| pix_bus | output | 8 | Output slice |
| bus_oe | output | 1 | Bus driver enable |
| slot_vld | output | 1 | High in slots that carry a slice |

## Verification
All eight channel codes are run in byte form with three distinct per-channel words whose bytes all differ. A wrong channel order, a swapped byte half or a miscounted sequence length therefore each yields a wrong value in a known slot. Nibble form is tried on a three-channel code and on a reversed two-channel code, which separates nibble order from channel order. Readback is tried in both formats on two consecutive pixels. A mode switch right after capture, a back-to-back stream and a run with the bus released show that captured modes stick, that the slices form a continuous stream, and that releasing the bus leaves the data untouched. The silent slot just before each expected first slice pins the latency to the exact cycle.

// File: rtl/pixout_fmt.sv
module pixout_fmt #(
  parameter int LAT_BYTE = 9,
  parameter int LAT_NIB  = 18,
  parameter int RB_W     = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_vld,
  input  logic [15:0] smp_r,
  input  logic [15:0] smp_g,
  input  logic [15:0] smp_b,
  input  logic [2:0]  chan_code,
  input  logic        nibble_mode,
  input  logic        rb_en,
  input  logic [RB_W-1:0] rb_word,
  input  logic        out_hiz,
  output logic [7:0]  pix_bus,
  output logic        bus_oe,
  output logic        slot_vld
);
  localparam int SW     = 16;
  localparam int TAP_B  = 2*LAT_BYTE - 1;
  localparam int TAP_N  = 2*LAT_NIB - 1;
  localparam int DEPTH  = (TAP_N > TAP_B) ? TAP_N + 1 : TAP_B + 1;

  typedef struct packed {
    logic          rb;
    logic          nib;
    logic [2:0]    code;
    logic [3*SW-1:0] d;
  } ent_t;

  function automatic logic [1:0] chan_at(input logic [2:0] code, input logic [1:0] pos);
    case (code)
      3'b000:  return pos;
      3'b001:  return 2'd0;
      3'b010:  return 2'd1;
      3'b011:  return 2'd2;
      3'b100:  return pos;
      3'b101:  return (pos == 2'd0) ? 2'd1 : 2'd0;
      3'b110:  return (pos == 2'd0) ? 2'd1 : 2'd2;
      default: return (pos == 2'd0) ? 2'd2 : 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] total_of(input ent_t e);
    logic [1:0] n;
    n = (e.code == 3'b000) ? 2'd3 : (e.code[2] ? 2'd2 : 2'd1);
    return e.nib ? {n, 2'b00} : {1'b0, n, 1'b0};
  endfunction

  function automatic logic [7:0] slice_of(input ent_t e, input logic [3:0] step);
    logic [1:0]    pos, part;
    logic [SW-1:0] w;
    pos  = e.nib ? step[3:2] : step[2:1];
    part = e.nib ? step[1:0] : {1'b0, step[0]};
    case (chan_at(e.code, pos))
      2'd0:    w = e.d[SW-1:0];
      2'd1:    w = e.d[2*SW-1:SW];
      default: w = e.d[3*SW-1:2*SW];
    endcase
    if (e.nib) begin
      case (part)
        2'd0:    return {w[15:12], 4'b0000};
        2'd1:    return {w[11:8],  4'b0000};
        2'd2:    return {w[7:4],   4'b0000};
        default: return {w[3:0],   4'b0000};
      endcase
    end
    return part[0] ? w[7:0] : w[15:8];
  endfunction

  ent_t       pipe_q [DEPTH];
  logic       pvld_q [DEPTH];
  ent_t       in_ent, take, cur_q;
  logic [3:0] step_q, cur_total;
  logic       busy_q, more, tap_b, tap_n;
  logic [SW-1:0] rb_pad;

  assign rb_pad = {{(SW-RB_W){1'b0}}, rb_word};
  assign in_ent = '{rb: rb_en, nib: nibble_mode, code: chan_code,
                    d: rb_en ? {rb_pad, rb_pad, rb_pad} : {smp_b, smp_g, smp_r}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pvld_q[i] <= 1'b0;
        pipe_q[i] <= '0;
      end
    end else begin
      pvld_q[0] <= smp_vld;
      pipe_q[0] <= in_ent;
      for (int i = 1; i < DEPTH; i++) begin
        pvld_q[i] <= pvld_q[i-1];
        pipe_q[i] <= pipe_q[i-1];
      end
    end
  end

  assign tap_n     = pvld_q[TAP_N] &&  pipe_q[TAP_N].nib;
  assign tap_b     = pvld_q[TAP_B] && !pipe_q[TAP_B].nib;
  assign take      = tap_n ? pipe_q[TAP_N] : pipe_q[TAP_B];
  assign cur_total = total_of(cur_q);
  assign more      = busy_q && ((step_q + 4'd1) < cur_total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      step_q   <= '0;
      busy_q   <= 1'b0;
      pix_bus  <= '0;
      slot_vld <= 1'b0;
      bus_oe   <= 1'b0;
    end else begin
      bus_oe <= !out_hiz;
      if (more) begin
        step_q   <= step_q + 4'd1;
        pix_bus  <= slice_of(cur_q, step_q + 4'd1);
        slot_vld <= 1'b1;
      end else if (tap_n || tap_b) begin
        cur_q    <= take;
        step_q   <= '0;
        busy_q   <= 1'b1;
        pix_bus  <= slice_of(take, 4'd0);
        slot_vld <= 1'b1;
      end else begin
        busy_q   <= 1'b0;
        step_q   <= '0;
        pix_bus  <= '0;
        slot_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixout_fmt_chk.sv
module pixout_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_hiz,
  input logic       bus_oe,
  input logic       slot_vld,
  input logic [7:0] pix_bus,
  input logic       cur_nib,
  input logic       cur_rb,
  input logic [3:0] step,
  input logic [3:0] total,
  input logic       busy
);
  assert_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |=> !bus_oe);
  assert_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hiz |=> bus_oe);
  assert_nib_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && cur_nib) |-> (pix_bus[3:0] == 4'h0));
  assert_rb_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && cur_rb && step == 4'd0) |->
      (cur_nib ? (pix_bus == 8'h00) : (pix_bus[7:2] == 6'd0)));
  assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step < total));
  assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && (step + 4'd1 < total)) |=> (slot_vld && step == $past(step) + 4'd1));
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld |-> (pix_bus == 8'h00));
endmodule

bind pixout_fmt pixout_fmt_chk chk (
  .clk(clk), .rst_n(rst_n), .out_hiz(out_hiz), .bus_oe(bus_oe),
  .slot_vld(slot_vld), .pix_bus(pix_bus), .cur_nib(cur_q.nib),
  .cur_rb(cur_q.rb), .step(step_q), .total(cur_total), .busy(busy_q)
);

// File: tb/pixout_fmt_test.sv
module pixout_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_r = '0, smp_g = '0, smp_b = '0;
  logic [2:0]  chan_code = '0;
  logic        nibble_mode = 1'b0;
  logic        rb_en = 1'b0;
  logic [9:0]  rb_word = '0;
  logic        out_hiz = 1'b0;
  logic [7:0]  pix_bus;
  logic        bus_oe, slot_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pixout_fmt uut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_r(smp_r), .smp_g(smp_g),
    .smp_b(smp_b), .chan_code(chan_code), .nibble_mode(nibble_mode), .rb_en(rb_en),
    .rb_word(rb_word), .out_hiz(out_hiz), .pix_bus(pix_bus), .bus_oe(bus_oe),
    .slot_vld(slot_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int seq_len(input logic [2:0] code);
    if (code == 3'b000) return 3;
    if (code inside {3'b001, 3'b010, 3'b011}) return 1;
    return 2;
  endfunction

  function automatic int seq_ch(input logic [2:0] code, input int pos);
    int s[3];
    case (code)
      3'b000: s = '{0, 1, 2};
      3'b001: s = '{0, 0, 0};
      3'b010: s = '{1, 1, 1};
      3'b011: s = '{2, 2, 2};
      3'b100: s = '{0, 1, 0};
      3'b101: s = '{1, 0, 0};
      3'b110: s = '{1, 2, 0};
      default: s = '{2, 0, 0};
    endcase
    return s[pos];
  endfunction

  function automatic logic [7:0] exp_slice(input logic [2:0] code, input bit nib,
      input logic [15:0] r, input logic [15:0] g, input logic [15:0] b, input int i);
    int per;
    int ch;
    int k;
    logic [15:0] w;
    per = nib ? 4 : 2;
    ch  = seq_ch(code, i / per);
    k   = i % per;
    w   = (ch == 0) ? r : (ch == 1) ? g : b;
    if (nib) return {w[15 - 4*k -: 4], 4'h0};
    return (k == 0) ? w[15:8] : w[7:0];
  endfunction

  // Capture one pixel, optionally change the mode right after capture, then check the slot train.
  task automatic run_pixel(input logic [2:0] code, input bit nib, input bit rb,
      input logic [15:0] r, input logic [15:0] g, input logic [15:0] b,
      input logic [9:0] rbw, input logic [2:0] code_after, input bit nib_after,
      input string req);
    int lat;
    int n;
    logic [15:0] er, eg, eb;
    lat = nib ? 36 : 18;
    n   = seq_len(code) * (nib ? 4 : 2);
    er = rb ? {6'd0, rbw} : r;
    eg = rb ? {6'd0, rbw} : g;
    eb = rb ? {6'd0, rbw} : b;
    @(negedge clk);
    chan_code = code; nibble_mode = nib; rb_en = rb; rb_word = rbw;
    smp_r = r; smp_g = g; smp_b = b; smp_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    smp_vld = 1'b0; chan_code = code_after; nibble_mode = nib_after;
    smp_r = ~r; smp_g = ~g; smp_b = ~b; rb_word = ~rbw;
    repeat (lat - 1) @(negedge clk);
    check(!slot_vld, {req, "/R5 early"}, slot_vld, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(slot_vld && pix_bus === exp_slice(code, nib, er, eg, eb, i),
            {req, "/R4/R5 slice"}, {slot_vld, pix_bus}, {1'b1, exp_slice(code, nib, er, eg, eb, i)});
    end
    @(negedge clk);
    check(!slot_vld && pix_bus == 8'h00, {req, "/R9/R10 end"}, {slot_vld, pix_bus}, 0);
    rb_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!slot_vld && pix_bus == 8'h00 && !bus_oe, "R10 reset", {slot_vld, bus_oe, pix_bus}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_oe, "R7 enable after reset", bus_oe, 1);
  endtask

  task automatic t_byte_codes();
    for (int c = 0; c < 8; c++)
      run_pixel(3'(c), 1'b0, 1'b0, 16'hA1B2, 16'hC3D4, 16'hE5F6, 10'h0, 3'(c), 1'b0, "R1/R2 byte code");
  endtask

  task automatic t_nibble();
    run_pixel(3'b000, 1'b1, 1'b0, 16'h1234, 16'h5678, 16'h9ABC, 10'h0, 3'b000, 1'b1, "R1/R3 nibble rgb");
    run_pixel(3'b111, 1'b1, 1'b0, 16'hFEDC, 16'h0F0F, 16'h8421, 10'h0, 3'b111, 1'b1, "R1/R3 nibble br");
  endtask

  task automatic t_readback();
    run_pixel(3'b000, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 10'h2A5, 3'b000, 1'b0, "R6 readback byte");
    run_pixel(3'b000, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 10'h2A5, 3'b000, 1'b0, "R6 readback repeat");
    run_pixel(3'b101, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 10'h3C7, 3'b101, 1'b1, "R6 readback nibble");
  endtask

  task automatic t_mode_change();
    run_pixel(3'b110, 1'b0, 1'b0, 16'h1111, 16'h2233, 16'h4455, 10'h0, 3'b000, 1'b1, "R8 byte then nibble");
    run_pixel(3'b011, 1'b1, 1'b0, 16'h0, 16'h0, 16'hBEEF, 10'h0, 3'b100, 1'b0, "R8 nibble then byte");
  endtask

  task automatic t_hiz();
    @(negedge clk);
    out_hiz = 1'b1;
    @(negedge clk);
    check(!bus_oe, "R7 released", bus_oe, 0);
    run_pixel(3'b100, 1'b0, 1'b0, 16'hCAFE, 16'hD00D, 16'h0, 10'h0, 3'b100, 1'b0, "R7 data under hiz");
    check(!bus_oe, "R7 still released", bus_oe, 0);
    out_hiz = 1'b0;
    @(negedge clk);
    check(bus_oe, "R7 driven again", bus_oe, 1);
  endtask

  task automatic t_stream();
    logic [15:0] w[3];
    w = '{16'h0102, 16'h0304, 16'h0506};
    @(negedge clk);
    chan_code = 3'b001; nibble_mode = 1'b0; rb_en = 1'b0;
    smp_r = w[0]; smp_vld = 1'b1;
    @(posedge clk);
    @(negedge clk); smp_vld = 1'b0;
    @(negedge clk); smp_vld = 1'b1; smp_r = w[1];
    @(negedge clk); smp_vld = 1'b0;
    @(negedge clk); smp_vld = 1'b1; smp_r = w[2];
    @(negedge clk); smp_vld = 1'b0;
    repeat (13) @(negedge clk);
    check(!slot_vld, "R9 stream early", slot_vld, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(slot_vld && pix_bus == ((i % 2) ? w[i/2][7:0] : w[i/2][15:8]), "R9 stream slice",
            {slot_vld, pix_bus}, {1'b1, ((i % 2) ? w[i/2][7:0] : w[i/2][15:8])});
    end
    @(negedge clk);
    check(!slot_vld, "R9 stream end", slot_vld, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_byte_codes();
    t_nibble();
    t_readback();
    t_mode_change();
    t_hiz();
    t_stream();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule